// File: doc/BRIEF.md
# Asynchronous Static RAM Controller With Byte Lanes

This block lets synchronous on-chip logic use an external asynchronous static RAM of 524,288 words by 16 bits. A requester presents an address, write data, a two-bit byte enable and a read/write flag under a valid/ready handshake. The controller turns each accepted request into one timed memory cycle on the chip-select, write-enable, output-enable and per-lane byte-select pins, which are all active low, and on a bidirectional data bus. Reads return their data with a one-cycle valid strobe.

Every timing minimum is a parameter counted in clock cycles. The defaults suit a 10 ns clock: a 6-cycle access, one cycle of address setup before the write strobe, a 4-cycle strobe, write data present 3 cycles before the strobe ends, and one recovery cycle. A write drops chip select first, lowers write enable one cycle later, and raises both on the same edge. Output enable stays high for the whole write. At least one idle cycle separates any two accesses, so the controller's data drivers are always off for a full cycle before output enable falls.

Top module: `sramc_top`

## Requirements
- R1: After reset and in every idle cycle, chip select, write enable, output enable and both byte selects are high, `req_ready` is 1 and `rd_valid` is 0.
- R2: An accepted read holds chip select and output enable low and write enable high for CYC_ACCESS (6) cycles, starting the cycle after acceptance. The address and the byte selects stay constant for the whole cycle. Byte select bit 0 is the complement of `req_be[0]` and gates `sram_dq[7:0]`; bit 1 is the complement of `req_be[1]` and gates `sram_dq[15:8]`.
- R3: `rd_valid` is a one-cycle pulse in the idle cycle that follows a read. It comes with `rd_data`, which holds the bus value sampled at the end of the last read cycle for enabled lanes and zero for disabled lanes.
- R4: An accepted write holds chip select low for CYC_ADDR_SETUP+CYC_STROBE (5) cycles. Write enable is low for CYC_STROBE (4) cycles, starting CYC_ADDR_SETUP (1) cycle into the write. Both rise on the same edge, the pins then stay high for the rest of the CYC_ACCESS cycles, and output enable is high throughout. The address is stable for at least the setup plus strobe cycles before the strobe ends.
- R5: During a write, the controller drives `req_wdata` onto each enabled lane from at least CYC_DATA_SETUP (3) cycles before the strobe ends until the end of the cycle. The value stays unchanged over that window.
- R6: A write changes only the memory lanes whose byte enable is set. Writes to the upper lane only, the lower lane only, or both read back accordingly.
- R7: `req_ready` is high only in idle cycles. A request is taken on an edge where both `req_valid` and `req_ready` are high. Successive acceptances are at least CYC_ACCESS+1 cycles apart.
- R8: Output enable is never low while the controller drives the bus, nor in the cycle right after it stopped driving.
- R9: A write with `req_be` equal to 0 runs a full write cycle with both byte selects high, and it leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables; bit 0 = lower lane, bit 1 = upper lane |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 19 | Memory address |
| sram_dq | inout | 16 | Memory data bus |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_bsel_n | output | 2 | Byte selects, active low; bit 0 = lower lane |

## Verification
The bench targets the following corner cases:
- Writes that touch only the upper lane, only the lower lane, or no lane. A controller that mixed up the byte-select polarity or the lane mapping would leave wrong bytes in the model memory.
- A read issued as soon as possible after a write. An implementation without the idle gap would lower output enable while its drivers still held the bus.
- Reads where the model returns valid data only after the full access count. A controller that sampled early, or that shortened the strobe, the address hold or the data setup, would capture filler data or trip the model's timing checks.
- Reads with lanes disabled. These must return zeros.
- Accesses at the lowest and highest addresses.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_WRITE = 2'd2
   } phase_e;
endpackage

// File: rtl/sramc_seq.sv
`timescale 1ns/1ps
module sramc_seq
   import sramc_pkg::*;
#(
   parameter int CYC_ACCESS     = 6,
   parameter int CYC_STROBE     = 4,
   parameter int CYC_ADDR_SETUP = 1,
   parameter int CYC_DATA_SETUP = 3,
   parameter bit LATE_DRIVE     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_we,
   output logic req_ready,
   output logic accept,
   output logic done,
   output logic capture,
   output logic cs_n,
   output logic we_n,
   output logic oe_n,
   output logic drv_en
);
   localparam int CNT_W = $clog2(CYC_ACCESS + 1);
   localparam logic [CNT_W-1:0] K_LAST   = CNT_W'(CYC_ACCESS - 1);
   localparam logic [CNT_W-1:0] K_WE_ON  = CNT_W'(CYC_ADDR_SETUP);
   localparam logic [CNT_W-1:0] K_WE_OFF = CNT_W'(CYC_ADDR_SETUP + CYC_STROBE);
   localparam logic [CNT_W-1:0] K_DRV_ON = CNT_W'(CYC_ADDR_SETUP + CYC_STROBE - CYC_DATA_SETUP);

   phase_e           ph, ph_nx;
   logic [CNT_W-1:0] cnt, cnt_nx;
   logic             in_wr, cs_d, we_d, oe_d, drv_d;

   assign req_ready = (ph == PH_IDLE);
   assign accept    = req_ready && req_valid;
   assign done      = (ph != PH_IDLE) && (cnt == K_LAST);
   assign capture   = (ph == PH_READ) && (cnt == K_LAST);

   always_comb begin
      ph_nx  = ph;
      cnt_nx = cnt;
      if (ph == PH_IDLE) begin
         if (req_valid) begin
            ph_nx  = req_we ? PH_WRITE : PH_READ;
            cnt_nx = '0;
         end
      end else if (cnt == K_LAST) begin
         ph_nx  = PH_IDLE;
         cnt_nx = '0;
      end else begin
         cnt_nx = cnt + 1'b1;
      end
   end

   // pins are decoded from the next phase so they switch with it
   assign in_wr = (ph_nx == PH_WRITE);
   assign cs_d  = (ph_nx == PH_READ) || (in_wr && (cnt_nx < K_WE_OFF));
   assign we_d  = in_wr && (cnt_nx >= K_WE_ON) && (cnt_nx < K_WE_OFF);
   assign oe_d  = (ph_nx == PH_READ);

   generate
      if (LATE_DRIVE) begin : g_late_drive
         assign drv_d = in_wr && (cnt_nx >= K_DRV_ON);
      end else begin : g_early_drive
         assign drv_d = in_wr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         cnt    <= '0;
         cs_n   <= 1'b1;
         we_n   <= 1'b1;
         oe_n   <= 1'b1;
         drv_en <= 1'b0;
      end else begin
         ph     <= ph_nx;
         cnt    <= cnt_nx;
         cs_n   <= !cs_d;
         we_n   <= !we_d;
         oe_n   <= !oe_d;
         drv_en <= drv_d;
      end
   end
endmodule

// File: rtl/sramc_lane.sv
`timescale 1ns/1ps
module sramc_lane #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              done,
   input  logic              be_in,
   input  logic [LANE_W-1:0] wd_in,
   input  logic              drv_en,
   input  logic              capture,
   inout  wire  [LANE_W-1:0] dq,
   output logic              sel_n,
   output logic [LANE_W-1:0] rd,
   output logic              drive
);
   logic              be_q;
   logic [LANE_W-1:0] wd_q;

   assign drive = drv_en && be_q;
   assign dq    = drive ? wd_q : {LANE_W{1'bz}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         be_q  <= 1'b0;
         wd_q  <= '0;
         sel_n <= 1'b1;
         rd    <= '0;
      end else begin
         if (accept) begin
            be_q  <= be_in;
            wd_q  <= wd_in;
            sel_n <= !be_in;
         end else if (done) begin
            sel_n <= 1'b1;
         end
         if (capture) rd <= be_q ? dq : '0;
      end
   end
endmodule

// File: rtl/sramc_top.sv
`timescale 1ns/1ps
module sramc_top #(
   parameter int ADDR_W         = 19,
   parameter int DATA_W         = 16,
   parameter int LANE_W         = 8,
   parameter int CYC_ACCESS     = 6,
   parameter int CYC_STROBE     = 4,
   parameter int CYC_ADDR_SETUP = 1,
   parameter int CYC_DATA_SETUP = 3,
   parameter bit LATE_DRIVE     = 1'b1,
   localparam int LANES         = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] sram_addr,
   inout  wire  [DATA_W-1:0] sram_dq,
   output logic              sram_cs_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [LANES-1:0]  sram_bsel_n
);
   if (DATA_W % LANE_W != 0) begin : g_bad_lanes
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (CYC_STROBE < 1) begin : g_bad_strobe
      $error("CYC_STROBE must be at least 1");
   end
   if (CYC_ADDR_SETUP + CYC_STROBE > CYC_ACCESS) begin : g_bad_cycle
      $error("setup plus strobe exceed the access length");
   end
   if (CYC_DATA_SETUP > CYC_ADDR_SETUP + CYC_STROBE) begin : g_bad_dsetup
      $error("data setup longer than setup plus strobe");
   end

   logic             accept, done, capture, drv_en;
   logic [LANES-1:0] lane_drive;
   logic [ADDR_W-1:0] addr_q;

   sramc_seq #(
      .CYC_ACCESS    (CYC_ACCESS),
      .CYC_STROBE    (CYC_STROBE),
      .CYC_ADDR_SETUP(CYC_ADDR_SETUP),
      .CYC_DATA_SETUP(CYC_DATA_SETUP),
      .LATE_DRIVE    (LATE_DRIVE)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_we   (req_we),
      .req_ready(req_ready),
      .accept   (accept),
      .done     (done),
      .capture  (capture),
      .cs_n     (sram_cs_n),
      .we_n     (sram_we_n),
      .oe_n     (sram_oe_n),
      .drv_en   (drv_en)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sramc_lane #(.LANE_W(LANE_W)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .accept (accept),
         .done   (done),
         .be_in  (req_be[g]),
         .wd_in  (req_wdata[g*LANE_W +: LANE_W]),
         .drv_en (drv_en),
         .capture(capture),
         .dq     (sram_dq[g*LANE_W +: LANE_W]),
         .sel_n  (sram_bsel_n[g]),
         .rd     (rd_data[g*LANE_W +: LANE_W]),
         .drive  (lane_drive[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (accept) addr_q <= req_addr;
         rd_valid <= capture;
      end
   end

   assign sram_addr = addr_q;
endmodule

// File: rtl/sramc_chk.sv
`timescale 1ns/1ps
module sramc_chk #(
   parameter int ADDR_W = 19,
   parameter int LANES  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rd_valid,
   input logic              cs_n,
   input logic              we_n,
   input logic              oe_n,
   input logic [LANES-1:0]  bsel_n,
   input logic [ADDR_W-1:0] addr,
   input logic [LANES-1:0]  bus_drive
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cs_n && we_n && oe_n && (&bsel_n))); // R1
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(addr)); // R2
   AST_BSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(bsel_n)); // R2
   AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R3
   AST_RDV_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> req_ready); // R3
   AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !cs_n); // R4
   AST_JOINT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> $rose(cs_n)); // R4
   AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> oe_n); // R4
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R7
   AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (|bus_drive) |-> oe_n); // R8
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $past(|bus_drive) |-> oe_n); // R8
endmodule

bind sramc_top sramc_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .rd_valid (rd_valid),
   .cs_n     (sram_cs_n),
   .we_n     (sram_we_n),
   .oe_n     (sram_oe_n),
   .bsel_n   (sram_bsel_n),
   .addr     (sram_addr),
   .bus_drive(lane_drive)
);

// File: tb/sramc_top_test.sv
`timescale 1ns/1ps
module sramc_top_test;
   localparam int CYC = 6, WP = 4, AS = 1, DS = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_we = 1'b0;
   logic [18:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, rd_valid;
   logic [15:0] rd_data;
   logic [18:0] sram_addr;
   wire  [15:0] sram_dq;
   logic        sram_cs_n, sram_we_n, sram_oe_n;
   logic [1:0]  sram_bsel_n;

   int n_vec = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   sramc_top uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr), .sram_dq(sram_dq),
      .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
      .sram_bsel_n(sram_bsel_n)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] init_word(input logic [18:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   // ---------------- behavioural memory with timing checks -------------
   logic [15:0] mem[int];
   logic [15:0] mem_out = 16'hDEAD;
   logic [1:0]  mem_drv;
   assign mem_drv = (!sram_cs_n && sram_we_n && !sram_oe_n) ? ~sram_bsel_n : 2'b00;
   assign sram_dq[7:0]  = mem_drv[0] ? mem_out[7:0]  : 8'bz;
   assign sram_dq[15:8] = mem_drv[1] ? mem_out[15:8] : 8'bz;

   function automatic logic [15:0] mem_rd(input logic [18:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return init_word(a);
   endfunction

   logic [18:0] p_addr = '0, l_addr = '0;
   logic [15:0] p_dq = '0, l_dq = '0, l_mask = '0;
   bit          p_st = 0, p_rc = 0;
   int          a_cnt = 0, d_cnt = 0, s_cnt = 0, acc = 0, l_dcnt = 0, l_acnt = 0;

   always @(negedge clk) begin
      bit st, rc;
      logic [15:0] mask;
      if (rst_n) begin
         st   = !sram_cs_n && !sram_we_n && (sram_bsel_n != 2'b11);
         rc   = !sram_cs_n && sram_we_n && !sram_oe_n;
         mask = {{8{!sram_bsel_n[1]}}, {8{!sram_bsel_n[0]}}};
         a_cnt = (sram_addr == p_addr) ? a_cnt + 1 : 1;
         d_cnt = ((sram_dq & mask) == (p_dq & mask)) ? d_cnt + 1 : 1;
         if (st) begin
            s_cnt++;
            l_dq = sram_dq; l_mask = mask; l_addr = sram_addr;
            l_dcnt = d_cnt; l_acnt = a_cnt;
         end else if (p_st) begin
            chk(s_cnt >= WP, "R4 strobe width", s_cnt, WP);
            chk(l_acnt >= AS + WP, "R4 address before strobe end", l_acnt, AS + WP);
            chk(l_dcnt >= DS, "R5 data setup before strobe end", l_dcnt, DS);
            mem[int'(l_addr)] = (mem_rd(l_addr) & ~l_mask) | (l_dq & l_mask);
            s_cnt = 0;
         end
         if (rc) acc = (p_rc && sram_addr == p_addr) ? acc + 1 : 1;
         else    acc = 0;
         mem_out = (acc >= CYC) ? mem_rd(sram_addr) : 16'hDEAD;
         p_addr = sram_addr; p_dq = sram_dq; p_st = st; p_rc = rc;
      end
   end

   // ---------------- cycle-by-cycle expectation queue ------------------
   typedef struct {
      logic        cs, we, oe;
      logic [1:0]  bsel;
      logic [18:0] addr;
      bit          chk_addr, wr, ready, rdv;
      logic [15:0] rdat;
      int          rtag;
   } exp_t;
   exp_t q[$];
   logic [15:0] shadow[int];
   bit prev_wr = 0;

   function automatic logic [15:0] sh_rd(input logic [18:0] a);
      if (shadow.exists(int'(a))) return shadow[int'(a)];
      return init_word(a);
   endfunction

   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (q.size() > 0) e = q.pop_front();
         else begin
            e.cs = 1; e.we = 1; e.oe = 1; e.bsel = 2'b11; e.addr = '0;
            e.chk_addr = 0; e.wr = 0; e.ready = 1; e.rdv = 0; e.rdat = '0; e.rtag = 0;
         end
         if (e.chk_addr) begin
            chk({sram_cs_n, sram_we_n, sram_oe_n} == {e.cs, e.we, e.oe},
                e.wr ? "R4 write strobe pins" : "R2 read pins",
                {sram_cs_n, sram_we_n, sram_oe_n}, {e.cs, e.we, e.oe});
            chk(sram_bsel_n == e.bsel, "R2 byte selects", sram_bsel_n, e.bsel);
            chk(sram_addr == e.addr, "R2 address held", sram_addr, e.addr);
         end else begin
            chk({sram_cs_n, sram_we_n, sram_oe_n, sram_bsel_n} == 5'h1F,
                "R1 idle pins", {sram_cs_n, sram_we_n, sram_oe_n, sram_bsel_n}, 5'h1F);
         end
         chk(req_ready == e.ready, "R7 ready", req_ready, e.ready);
         chk(rd_valid == e.rdv, "R3 rd_valid", rd_valid, e.rdv);
         if (e.rdv) begin
            case (e.rtag)
               1: chk(rd_data == e.rdat, "R6 masked write readback", rd_data, e.rdat);
               2: chk(rd_data == e.rdat, "R9 empty write left memory", rd_data, e.rdat);
               default: chk(rd_data == e.rdat, "R3 read data", rd_data, e.rdat);
            endcase
         end
         if (!sram_oe_n && prev_wr)
            chk(0, "R8 output enable right after write", sram_oe_n, 1);
         else if (!sram_oe_n)
            chk(1, "R8 turnaround", sram_oe_n, sram_oe_n);
         prev_wr = e.wr;
      end
   end

   task automatic issue(input bit we, input logic [18:0] a, input logic [1:0] be,
                        input logic [15:0] d, input int rtag);
      exp_t e;
      logic [15:0] s;
      do begin @(posedge clk); #1; end while (!(q.size() == 0 || q[0].ready));
      req_valid = 1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
      @(posedge clk); #1;
      req_valid = 0; req_wdata = ~d; req_addr = ~a; req_be = ~be;
      for (int k = 0; k < CYC; k++) begin
         e.cs   = we ? !(k < AS + WP) : 1'b0;
         e.we   = we ? !(k >= AS && k < AS + WP) : 1'b1;
         e.oe   = we ? 1'b1 : 1'b0;
         e.bsel = ~be; e.addr = a; e.chk_addr = 1; e.wr = we; e.ready = 0;
         e.rdv = 0; e.rdat = '0; e.rtag = 0;
         q.push_back(e);
      end
      s = sh_rd(a);
      e.cs = 1; e.we = 1; e.oe = 1; e.bsel = 2'b11; e.addr = '0; e.chk_addr = 0;
      e.wr = 0; e.ready = 1; e.rdv = !we; e.rtag = rtag;
      e.rdat = {be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00};
      q.push_back(e);
      if (we) begin
         if (be[0]) s[7:0]  = d[7:0];
         if (be[1]) s[15:8] = d[15:8];
         shadow[int'(a)] = s;
      end
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic [31:0] lfsr = 32'h1F2E3D4C;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({sram_cs_n, sram_we_n, sram_oe_n, sram_bsel_n} == 5'h1F, "R1 reset pins",
          {sram_cs_n, sram_we_n, sram_oe_n, sram_bsel_n}, 5'h1F);
      chk(rd_valid == 0, "R1 reset rd_valid", rd_valid, 0);
      chk(req_ready == 1, "R1 reset ready", req_ready, 1);
      @(posedge clk); #1 rst_n = 1;
      repeat (2) @(posedge clk);
      issue(1, 19'h00000, 2'b11, 16'h1234, 0);
      issue(0, 19'h00000, 2'b11, 16'h0, 0);        // R8 read right after write
      issue(1, 19'h7FFFF, 2'b10, 16'hABCD, 0);      // R6 upper only
      issue(0, 19'h7FFFF, 2'b11, 16'h0, 1);
      issue(1, 19'h7FFFF, 2'b01, 16'h9955, 0);      // R6 lower only
      issue(0, 19'h7FFFF, 2'b11, 16'h0, 1);
      issue(1, 19'h00100, 2'b00, 16'hFFFF, 0);      // R9 no lane
      issue(0, 19'h00100, 2'b11, 16'h0, 2);
      issue(0, 19'h00000, 2'b01, 16'h0, 0);         // R3 upper lane masked
      issue(0, 19'h00000, 2'b10, 16'h0, 0);         // R3 lower lane masked
      issue(0, 19'h00000, 2'b00, 16'h0, 0);         // R3 nothing enabled
      issue(0, 19'h12345, 2'b11, 16'h0, 0);         // back-to-back reads
      issue(0, 19'h54321, 2'b11, 16'h0, 0);
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         issue(lfsr[5], {lfsr[20:18], 12'h0, lfsr[3:0]}, lfsr[7:6], lfsr[31:16], 1);
      end
      while (q.size() > 0) @(posedge clk);
      repeat (4) @(posedge clk);
      finish_run();
   end
endmodule